// File: doc/BRIEF.md
# Add-Family Carry and Overflow Flag Unit

This unit forms the 64-bit result of a family of add and subtract-from operations. From the same addition it also produces the carry and overflow status flags. An operation code selects three things: whether operand A enters the adder inverted, what the second operand is (register B, the sign-extended 16-bit immediate, all ones or zero), and the carry-in (0, 1, the stored carry flag or the stored overflow flag). The unit then reports a 64-bit carry, a carry out of the low 32 bits, and the matching signed-overflow indications at both widths.

The stored CA, OV and SO flags are inputs. The new flag values are outputs, and each flag group has its own write-enable, so the surrounding pipeline can commit only the flags the operation owns. One operation is an alternate-carry add: it feeds the stored OV into the carry chain and returns its carries through the overflow outputs rather than the carry outputs. The unit is purely combinational, so every output follows the current inputs within the same cycle.

Top module: `addcy_flags_unit`

## Requirements
- R1: The operation code `op_sel` maps as follows. 0 add: A+B+0. 1 add-immediate-carrying: A+imm+0. 2 subtract-from: ~A+B+1. 3 subtract-from-immediate: ~A+imm+1. 4 extended add: A+B+CA. 5 extended subtract-from: ~A+B+CA. 6 add-minus-one: A+all-ones+CA. 7 subtract-from-minus-one: ~A+all-ones+CA. 8 add-zero: A+0+CA. 9 subtract-from-zero: ~A+0+CA. 11 alternate-carry add: A+B+OV. `sum` is the low 64 bits of that addition.
- R2: The 16-bit immediate is sign-extended to 64 bits: upper bits are copies of bit 15.
- R3: `ca_out` is the carry out of the full 64-bit addition, and `ca32_out` is the carry out of bits 31..0 of the same addition, carry-in included.
- R4: For every operation other than 11, `ov_out` is 1 exactly when the carry out of bit 63 differs from the carry out of bits 62..0. `ov32_out` is the same comparison between the carries out of bits 31..0 and bits 30..0.
- R5: For operation 11, `ov_out` and `ov32_out` carry the 64-bit and 32-bit carry outs, `ov_we` is 1 whatever `oe` is, and `ca_we` and `so_we` are 0.
- R6: When `so_we` is 1, `so_out` equals `so_in` OR `ov_out`, so a set SO is never cleared. When `so_we` is 0, `so_out` equals `so_in`.
- R7: For operations 0 to 10, `ca_we` is 1, and `ov_we` and `so_we` both equal `oe`.
- R8: For the unrecognised codes 12 to 15, `ca_we`, `ov_we` and `so_we` are all 0.
- R9: Operation 10 (negate) computes ~A+0+1. Negating 0 gives 0 with `ca_out` 1, and negating 0x8000_0000_0000_0000 gives the same value with `ov_out` 1.
- R10: The unit holds no state. After any change of inputs, the outputs match the new inputs before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| imm16 | input | 16 | Signed immediate |
| op_sel | input | 4 | Operation code (see R1) |
| oe | input | 1 | Overflow recording enable |
| ca_in | input | 1 | Stored carry flag |
| ov_in | input | 1 | Stored overflow flag |
| so_in | input | 1 | Stored summary-overflow flag |
| sum | output | 64 | 64-bit result |
| ca_out | output | 1 | New 64-bit carry |
| ca32_out | output | 1 | New 32-bit carry |
| ov_out | output | 1 | New overflow (or carry for op 11) |
| ov32_out | output | 1 | New 32-bit overflow (or carry for op 11) |
| so_out | output | 1 | New summary overflow |
| ca_we | output | 1 | Write-enable for CA and CA32 |
| ov_we | output | 1 | Write-enable for OV and OV32 |
| so_we | output | 1 | Write-enable for SO |

## Verification
Random operands are drawn from both uniform values and boundary values: zero, all ones, the most positive and most negative values at both widths, and patterns that sit exactly at a 32-bit carry boundary. The boundary draws separate the 31-, 32-, 63- and 64-bit carry taps, which a uniform draw almost never tells apart. The code, the immediate sign bit, `oe` and the stored flags are varied freely, including the unrecognised codes, so that the carry-in choice, immediate extension and write-enable routing are each exposed. Directed cases cover negation of zero and of the most negative value, 32-bit-only overflow, the alternate-carry add with OV set, and a set SO that must stay set.

// File: rtl/addcy_pkg.sv
package addcy_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDIC  = 4'd1,
        OP_SUBF   = 4'd2,
        OP_SUBFIC = 4'd3,
        OP_ADDE   = 4'd4,
        OP_SUBFE  = 4'd5,
        OP_ADDME  = 4'd6,
        OP_SUBFME = 4'd7,
        OP_ADDZE  = 4'd8,
        OP_SUBFZE = 4'd9,
        OP_NEG    = 4'd10,
        OP_ADDALT = 4'd11
    } add_op_e;

    // second-operand source
    typedef enum logic [1:0] {
        YSRC_REG  = 2'd0,
        YSRC_IMM  = 2'd1,
        YSRC_ONES = 2'd2,
        YSRC_ZERO = 2'd3
    } ysrc_e;

    // carry-in source
    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_CA   = 2'd2,
        CIN_OV   = 2'd3
    } cin_e;

    typedef struct packed {
        logic  known;    // recognised code
        logic  flip_x;   // invert operand A
        ysrc_e ysrc;
        cin_e  csrc;
        logic  alt_ov;   // carries go to the OV pair
    } op_ctl_t;

    typedef struct packed {
        logic c_lo_m1;   // out of the low half minus one bit
        logic c_lo;      // out of the low half
        logic c_hi_m1;   // out of the full width minus one bit
        logic c_hi;      // out of the full width
    } carry_taps_t;

    function automatic op_ctl_t decode_op(input logic [3:0] code);
        op_ctl_t c;
        c = '{known: 1'b1, flip_x: 1'b0, ysrc: YSRC_REG, csrc: CIN_ZERO, alt_ov: 1'b0};
        case (code)
            OP_ADD:    ;
            OP_ADDIC:  c.ysrc = YSRC_IMM;
            OP_SUBF:   begin c.flip_x = 1'b1; c.csrc = CIN_ONE; end
            OP_SUBFIC: begin c.flip_x = 1'b1; c.ysrc = YSRC_IMM; c.csrc = CIN_ONE; end
            OP_ADDE:   c.csrc = CIN_CA;
            OP_SUBFE:  begin c.flip_x = 1'b1; c.csrc = CIN_CA; end
            OP_ADDME:  begin c.ysrc = YSRC_ONES; c.csrc = CIN_CA; end
            OP_SUBFME: begin c.flip_x = 1'b1; c.ysrc = YSRC_ONES; c.csrc = CIN_CA; end
            OP_ADDZE:  begin c.ysrc = YSRC_ZERO; c.csrc = CIN_CA; end
            OP_SUBFZE: begin c.flip_x = 1'b1; c.ysrc = YSRC_ZERO; c.csrc = CIN_CA; end
            OP_NEG:    begin c.flip_x = 1'b1; c.ysrc = YSRC_ZERO; c.csrc = CIN_ONE; end
            OP_ADDALT: begin c.csrc = CIN_OV; c.alt_ov = 1'b1; end
            default:   c.known = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/addcy_opsel.sv
module addcy_opsel
    import addcy_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [IMM_W-1:0]  imm_in,
    input  op_ctl_t           ctl,
    input  logic              ca_flag,
    input  logic              ov_flag,
    output logic [DATA_W-1:0] x_op,
    output logic [DATA_W-1:0] y_op,
    output logic              cin
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    assign imm_ext = {{EXT_W{imm_in[IMM_W-1]}}, imm_in};
    assign x_op    = ctl.flip_x ? ~a_in : a_in;

    always_comb begin
        unique case (ctl.ysrc)
            YSRC_REG:  y_op = b_in;
            YSRC_IMM:  y_op = imm_ext;
            YSRC_ONES: y_op = '1;
            default:   y_op = '0;
        endcase
        unique case (ctl.csrc)
            CIN_ZERO: cin = 1'b0;
            CIN_ONE:  cin = 1'b1;
            CIN_CA:   cin = ca_flag;
            default:  cin = ov_flag;
        endcase
    end
endmodule

// File: rtl/addcy_adder.sv
module addcy_adder
    import addcy_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LOW_W  = 32
) (
    input  logic [DATA_W-1:0] x_op,
    input  logic [DATA_W-1:0] y_op,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output carry_taps_t       taps
);
    localparam int S0_W = LOW_W - 1;           // bits below the low-half top bit
    localparam int S2_W = DATA_W - LOW_W - 1;  // bits between halves' top bits

    logic [S0_W:0] seg0;
    logic [1:0]    seg1;
    logic [S2_W:0] seg2;
    logic [1:0]    seg3;

    // the chain is cut at each flag tap, giving the carry out of every segment
    assign seg0 = {1'b0, x_op[S0_W-1:0]} + {1'b0, y_op[S0_W-1:0]}
                + {{S0_W{1'b0}}, cin};
    assign seg1 = {1'b0, x_op[LOW_W-1]} + {1'b0, y_op[LOW_W-1]} + {1'b0, seg0[S0_W]};
    assign seg2 = {1'b0, x_op[DATA_W-2:LOW_W]} + {1'b0, y_op[DATA_W-2:LOW_W]}
                + {{S2_W{1'b0}}, seg1[1]};
    assign seg3 = {1'b0, x_op[DATA_W-1]} + {1'b0, y_op[DATA_W-1]} + {1'b0, seg2[S2_W]};

    assign sum  = {seg3[0], seg2[S2_W-1:0], seg1[0], seg0[S0_W-1:0]};
    assign taps = '{c_lo_m1: seg0[S0_W], c_lo: seg1[1], c_hi_m1: seg2[S2_W], c_hi: seg3[1]};
endmodule

// File: rtl/addcy_flagmux.sv
module addcy_flagmux
    import addcy_pkg::*;
(
    input  op_ctl_t     ctl,
    input  carry_taps_t taps,
    input  logic        oe,
    input  logic        so_in,
    output logic        ca_out,
    output logic        ca32_out,
    output logic        ov_out,
    output logic        ov32_out,
    output logic        so_out,
    output logic        ca_we,
    output logic        ov_we,
    output logic        so_we
);
    logic ovf_hi, ovf_lo;

    assign ovf_hi = taps.c_hi ^ taps.c_hi_m1;
    assign ovf_lo = taps.c_lo ^ taps.c_lo_m1;

    always_comb begin
        ca_out   = taps.c_hi;
        ca32_out = taps.c_lo;
        if (ctl.alt_ov) begin
            ov_out   = taps.c_hi;
            ov32_out = taps.c_lo;
            ca_we    = 1'b0;
            ov_we    = 1'b1;
            so_we    = 1'b0;
        end else begin
            ov_out   = ovf_hi;
            ov32_out = ovf_lo;
            ca_we    = ctl.known;
            ov_we    = ctl.known & oe;
            so_we    = ctl.known & oe;
        end
        so_out = so_in | (so_we & ov_out);
    end
endmodule

// File: rtl/addcy_flags_unit.sv
module addcy_flags_unit
    import addcy_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LOW_W  = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [3:0]        op_sel,
    input  logic              oe,
    input  logic              ca_in,
    input  logic              ov_in,
    input  logic              so_in,
    output logic [DATA_W-1:0] sum,
    output logic              ca_out,
    output logic              ca32_out,
    output logic              ov_out,
    output logic              ov32_out,
    output logic              so_out,
    output logic              ca_we,
    output logic              ov_we,
    output logic              so_we
);
    op_ctl_t           ctl;
    logic [DATA_W-1:0] x_op, y_op;
    logic              cin;
    carry_taps_t       taps;

    assign ctl = decode_op(op_sel);

    addcy_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .a_in(opa), .b_in(opb), .imm_in(imm16), .ctl(ctl),
        .ca_flag(ca_in), .ov_flag(ov_in),
        .x_op(x_op), .y_op(y_op), .cin(cin)
    );

    addcy_adder #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_adder (
        .x_op(x_op), .y_op(y_op), .cin(cin), .sum(sum), .taps(taps)
    );

    addcy_flagmux u_flags (
        .ctl(ctl), .taps(taps), .oe(oe), .so_in(so_in),
        .ca_out(ca_out), .ca32_out(ca32_out), .ov_out(ov_out), .ov32_out(ov32_out),
        .so_out(so_out), .ca_we(ca_we), .ov_we(ov_we), .so_we(so_we)
    );
endmodule

// File: rtl/addcy_flags_checker.sv
module addcy_flags_checker #(
    parameter int DATA_W = 64
) (
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [3:0]        op_sel,
    input logic              oe,
    input logic              so_in,
    input logic [DATA_W-1:0] sum,
    input logic              ca_out,
    input logic              ov_out,
    input logic              so_out,
    input logic              ca_we,
    input logic              ov_we,
    input logic              so_we
);
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic known_in;
    assign known_in = !$isunknown({opa, opb, op_sel, oe, so_in});

    always_comb begin
        if (known_in) begin
            p_unknown_code_silent_r8: assert (!(op_sel >= 4'd12) || !(ca_we | ov_we | so_we))
                else $error("unrecognised code raised a write-enable");
            p_alt_add_routing_r5: assert (!(op_sel == 4'd11) || (!ca_we && ov_we && !so_we))
                else $error("alternate-carry add enables wrong");
            p_normal_enables_r7: assert (!(op_sel <= 4'd10) || (ca_we && ov_we == oe && so_we == oe))
                else $error("write-enables do not follow oe");
            p_so_sticky_r6: assert (!so_in || so_out)
                else $error("SO cleared");
            p_so_hold_r6: assert (so_we || so_out == so_in)
                else $error("SO changed without enable");
            p_neg_zero_r9: assert (!(op_sel == 4'd10 && opa == '0) || (sum == '0 && ca_out))
                else $error("negate of zero wrong");
            p_neg_min_r9: assert (!(op_sel == 4'd10 && opa == MIN_NEG) || (sum == MIN_NEG && ov_out))
                else $error("negate of most negative wrong");
            p_add_zero_ident_r1: assert (!(op_sel == 4'd0 && opb == '0) || (sum == opa && !ca_out && !ov_out))
                else $error("add of zero changed operand");
        end
    end
endmodule

bind addcy_flags_unit addcy_flags_checker #(.DATA_W(DATA_W)) u_checker (
    .opa(opa), .opb(opb), .op_sel(op_sel), .oe(oe), .so_in(so_in),
    .sum(sum), .ca_out(ca_out), .ov_out(ov_out), .so_out(so_out),
    .ca_we(ca_we), .ov_we(ov_we), .so_we(so_we)
);

// File: tb/addcy_flags_unit_bench.sv
`timescale 1ns/1ps
module addcy_flags_unit_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [63:0] opa, opb, sum;
    logic [15:0] imm16;
    logic [3:0]  op_sel;
    logic oe, ca_in, ov_in, so_in;
    logic ca_out, ca32_out, ov_out, ov32_out, so_out, ca_we, ov_we, so_we;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    addcy_flags_unit u_addcy_flags_unit (
        .opa(opa), .opb(opb), .imm16(imm16), .op_sel(op_sel), .oe(oe),
        .ca_in(ca_in), .ov_in(ov_in), .so_in(so_in), .sum(sum),
        .ca_out(ca_out), .ca32_out(ca32_out), .ov_out(ov_out), .ov32_out(ov32_out),
        .so_out(so_out), .ca_we(ca_we), .ov_we(ov_we), .so_we(so_we)
    );

    typedef struct packed {
        logic [63:0] s;
        logic ca, ca32, ov, ov32, so, cwe, owe, swe;
    } exp_t;

    function automatic logic carry_at(input logic [63:0] x, input logic [63:0] y,
                                      input logic c, input int w);
        logic [64:0] t;
        logic [64:0] m;
        m = (65'd1 << w) - 65'd1;
        t = ({1'b0, x} & m) + ({1'b0, y} & m) + {64'd0, c};
        return t[w];
    endfunction

    function automatic exp_t model(input logic [63:0] a, input logic [63:0] b,
                                   input logic [15:0] im, input logic [3:0] code,
                                   input logic e, input logic ca, input logic ov,
                                   input logic so);
        exp_t r;
        logic [63:0] x, y, ims;
        logic c, k64, k32;
        ims = {{48{im[15]}}, im};
        x = a; y = b; c = 1'b0;
        case (code)
            4'd1:  y = ims;
            4'd2:  begin x = ~a; c = 1'b1; end
            4'd3:  begin x = ~a; y = ims; c = 1'b1; end
            4'd4:  c = ca;
            4'd5:  begin x = ~a; c = ca; end
            4'd6:  begin y = '1; c = ca; end
            4'd7:  begin x = ~a; y = '1; c = ca; end
            4'd8:  begin y = '0; c = ca; end
            4'd9:  begin x = ~a; y = '0; c = ca; end
            4'd10: begin x = ~a; y = '0; c = 1'b1; end
            4'd11: c = ov;
            default: ;
        endcase
        r.s  = x + y + {63'd0, c};
        k64  = carry_at(x, y, c, 64);
        k32  = carry_at(x, y, c, 32);
        r.ca = k64; r.ca32 = k32;
        if (code == 4'd11) begin
            r.ov = k64; r.ov32 = k32;
            r.cwe = 0; r.owe = 1; r.swe = 0;
        end else begin
            r.ov   = k64 ^ carry_at(x, y, c, 63);
            r.ov32 = k32 ^ carry_at(x, y, c, 31);
            r.cwe  = (code <= 4'd10);
            r.owe  = (code <= 4'd10) & e;
            r.swe  = (code <= 4'd10) & e;
        end
        r.so = so | (r.swe & r.ov);
        return r;
    endfunction

    task automatic chk1(input string tag, input logic [63:0] act, input logic [63:0] ex);
        n_vec++;
        if (act !== ex) begin
            n_bad++;
            $display("FAIL %s op=%0d actual=%h expected=%h", tag, op_sel, act, ex);
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [15:0] im,
                         input logic [3:0] code, input logic e, input logic ca,
                         input logic ov, input logic so);
        exp_t r;
        @(negedge clk);
        opa = a; opb = b; imm16 = im; op_sel = code; oe = e;
        ca_in = ca; ov_in = ov; so_in = so;
        r = model(a, b, im, code, e, ca, ov, so);
        #1;
        // R10: outputs already reflect this vector within the cycle
        chk1(code == 4'd10 ? "R9 sum" : (code == 4'd1 || code == 4'd3) ? "R2 sum" : "R1 sum", sum, r.s);
        chk1("R3 ca_out",   {63'd0, ca_out},   {63'd0, r.ca});
        chk1("R3 ca32_out", {63'd0, ca32_out}, {63'd0, r.ca32});
        chk1(code == 4'd11 ? "R5 ov_out" : "R4 ov_out",     {63'd0, ov_out},   {63'd0, r.ov});
        chk1(code == 4'd11 ? "R5 ov32_out" : "R4 ov32_out", {63'd0, ov32_out}, {63'd0, r.ov32});
        chk1("R6 so_out",   {63'd0, so_out},   {63'd0, r.so});
        chk1(code >= 4'd12 ? "R8 enables" : code == 4'd11 ? "R5 enables" : "R7 enables",
             {61'd0, ca_we, ov_we, so_we}, {61'd0, r.cwe, r.owe, r.swe});
    endtask

    function automatic logic [63:0] pick_val(input int unsigned sel);
        case (sel % 10)
            0: return 64'd0;
            1: return '1;
            2: return 64'h7FFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h0000_0000_7FFF_FFFF;
            5: return 64'h0000_0000_8000_0000;
            6: return 64'h0000_0000_FFFF_FFFF;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h0BADC0DE);
        opa = '0; opb = '0; imm16 = '0; op_sel = '0; oe = 0; ca_in = 0; ov_in = 0; so_in = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs give zero sum and no flags (R1, R7)
        apply(64'd0, 64'd0, 16'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        // directed corners
        apply(64'd0, 64'd5, 16'd0, 4'd10, 1'b1, 1'b0, 1'b0, 1'b0);                 // R9 neg 0
        apply(64'h8000_0000_0000_0000, 64'd0, 16'd0, 4'd10, 1'b1, 1'b0, 1'b0, 1'b0); // R9 neg min
        apply(64'h0000_0000_7FFF_FFFF, 64'd1, 16'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0);  // R4 ov32 only
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 4'd11, 1'b0, 1'b0, 1'b1, 1'b0); // R5 alt
        apply(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1);  // R6 sticky
        apply(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);  // R7 oe low
        apply(64'd10, 64'd0, 16'h8000, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0);               // R2 neg imm
        apply(64'd10, 64'd0, 16'h7FFF, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0);               // R2 pos imm
        apply(64'd3, 64'd4, 16'd0, 4'd6, 1'b1, 1'b1, 1'b0, 1'b0);                   // R1 addme
        apply(64'd3, 64'd4, 16'd0, 4'd13, 1'b1, 1'b1, 1'b1, 1'b1);                  // R8 unknown
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'd0, 4'd8, 1'b1, 1'b1, 1'b0, 1'b0); // R3 addze wrap
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] code;
            code = ($urandom % 8 == 0) ? 4'(12 + $urandom % 4) : 4'($urandom % 12);
            apply(pick_val($urandom), pick_val($urandom), 16'($urandom), code,
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL R10 watchdog expired actual=hung expected=complete");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule